// File: doc/BRIEF.md
# Vector Loop Issue Sequencer

This block is the control sequencer that sits between instruction fetch and a single execution unit. It owns the architectural program counter, the machine state word and the vector state, which is a vector length plus the index of the current element. At fetch it samples all three together with the decoded flags of the incoming instruction. For a vector-prefixed instruction it then starts the execution unit once per element. The element index is kept in a local counter and written back after each element, so the vector state is never read again during the loop.

A loop ends in one of three ways. The normal way is that the next index reaches the vector length or the instruction is decoded as having no vector output. The second is that execution reports a write to the program counter or to the vector state. The sequencer treats that as an exception and returns to fetch without stepping. The third applies to length-setting, branch and trap instructions: they never loop, they may rewrite the state registers, and carrying a vector prefix on them is reported as illegal. A scalar instruction runs as a loop of exactly one element and leaves the element index alone.

Top module: `vloop_seq`

## Requirements
- R1: After reset `fetch_req` is 1, `ex_start` is 0, `pc_o` equals `RESET_PC`, and `msr_o`, `vl_o` and `step_o` are zero. `ex_start` is never high while `fetch_req` is high.
- R2: For every element, `ex_msr` equals the value `msr_o` had when the instruction was accepted. `ex_vec` equals the accepted prefix flag and `ex_cls` equals the accepted class.
- R3: `ex_start` is a one-cycle pulse. It is high in the cycle after `fetch_ack` is accepted, and in the cycle after an `ex_done` that continues the loop.
- R4: The first `ex_step` equals `step_o` at acceptance. Each further element increments it by one, and `step_o` equals `ex_step` while `ex_start` is high.
- R5: For a prefixed normal instruction (class 0), when `ex_step + 1 >= vl` at `ex_done`, the step resets to 0 and `pc_o` advances by `WIDE_BYTES` (8). The block returns to fetch and `pc_o` does not change while outside fetch.
- R6: For a prefixed normal instruction with `fetch_nvo = 1`, the loop ends after its first element in the same way as R5.
- R7: If `ex_pc_we` or `ex_vst_we` is set at `ex_done` of a class-0 instruction, `exc_o` pulses for one cycle. The written values are taken, the step is not incremented, and the block returns to fetch.
- R8: A non-prefixed instruction of class 1 (length set), 2 (branch) or 3 (trap) executes once and applies every write enable. `pc_o` advances by `NARROW_BYTES` (4) unless `ex_pc_we` is set, and `exc_o` stays 0.
- R9: A prefixed instruction of class 1, 2 or 3 pulses `illegal_o` for one cycle and gives no `ex_start`. `pc_o`, `msr_o`, `vl_o` and `step_o` are unchanged.
- R10: A non-prefixed class-0 instruction without state writes executes once with `ex_step = step_o`. `step_o` is unchanged and `pc_o` advances by 4.
- R11: A prefixed class-0 instruction accepted while `step_o >= vl_o` (including `vl_o = 0`) gives no `ex_start`. The step becomes 0 and `pc_o` advances by 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_req | output | 1 | Sequencer is waiting for the next instruction |
| fetch_pc | output | PC_W | Address of the instruction to fetch |
| fetch_ack | input | 1 | A decoded instruction is presented and accepted this cycle |
| fetch_pfx | input | 1 | Instruction carries the vector prefix |
| fetch_cls | input | 2 | Class: 0 normal, 1 length set, 2 branch, 3 trap |
| fetch_nvo | input | 1 | Instruction has no vector output |
| ex_start | output | 1 | Start one element on the execution unit |
| ex_step | output | VL_W | Element index of the started element |
| ex_vec | output | 1 | Latched prefix flag |
| ex_cls | output | 2 | Latched class |
| ex_msr | output | MSR_W | Machine state captured at fetch |
| ex_done | input | 1 | Execution of the current element finished |
| ex_pc_we | input | 1 | Execution writes the program counter |
| ex_pc_wd | input | PC_W | Program counter write data |
| ex_msr_we | input | 1 | Execution writes the machine state |
| ex_msr_wd | input | MSR_W | Machine state write data |
| ex_vst_we | input | 1 | Execution writes the vector state |
| ex_vl_wd | input | VL_W | Vector length write data |
| ex_step_wd | input | VL_W | Element index write data |
| pc_o | output | PC_W | Architectural program counter |
| msr_o | output | MSR_W | Architectural machine state |
| vl_o | output | VL_W | Architectural vector length |
| step_o | output | VL_W | Architectural element index |
| illegal_o | output | 1 | One-cycle pulse: prefix on a non-loopable class |
| exc_o | output | 1 | One-cycle pulse: loop left on a state write |

## Verification
A wrong step counter is visible at the next `ex_start`, where `ex_step` is compared with the index predicted from the fetched step. It also shows one cycle after the loop ends, in `step_o` and `pc_o`. A wrong state-machine decision shows within a cycle of acceptance or completion: an `ex_start` is missing or extra, or an illegal or exception pulse is missing or extra. The bench counts these pulses per instruction. A stale snapshot of the machine state shows at the first element after a trap rewrites it.

// File: rtl/vloop_pkg.sv
// Shared types for the vector loop issue sequencer.
package vloop_pkg;
    // Instruction class as delivered by the decoder; only class 0 may loop.
    typedef enum logic [1:0] {
        CLS_NORM   = 2'd0,
        CLS_SETLEN = 2'd1,
        CLS_BRANCH = 2'd2,
        CLS_TRAP   = 2'd3
    } icls_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_st_e;

    // Decoded flags captured at fetch.
    typedef struct packed {
        logic  pfx;
        icls_e cls;
        logic  nvo;
    } dec_t;
endpackage

// File: rtl/vloop_step.sv
// Local element counter. Takes the architectural step and length once at
// fetch (cap) and steps locally afterwards (adv). Assumes cap and adv are
// never high together.
module vloop_step #(
    parameter int VL_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap,
    input  logic            adv,
    input  logic [VL_W-1:0] step_in,
    input  logic [VL_W-1:0] vl_in,
    output logic [VL_W-1:0] cur_step,
    output logic [VL_W-1:0] step_nxt,
    output logic            skip,
    output logic            last
);
    localparam int CW = VL_W + 1;

    logic [VL_W-1:0] cur_vl;
    logic [CW-1:0]   nxt_w;

    // Next index one bit wider so that the compare cannot wrap.
    always_comb begin
        nxt_w    = {1'b0, cur_step} + CW'(1);
        step_nxt = nxt_w[VL_W-1:0];
        last     = (nxt_w >= {1'b0, cur_vl});
        skip     = (step_in >= vl_in);
    end

    // Capture at fetch, increment per continued element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_step <= '0;
            cur_vl   <= '0;
        end else if (cap) begin
            cur_step <= step_in;
            cur_vl   <= vl_in;
        end else if (adv) begin
            cur_step <= step_nxt;
        end
    end
endmodule

// File: rtl/vloop_regs.sv
// Architectural state: program counter, machine state, vector length and
// element index, plus the machine state snapshot taken at fetch.
// Writes from execution (when commit) take priority over sequencer updates.
module vloop_regs #(
    parameter int          PC_W         = 32,
    parameter int          MSR_W        = 16,
    parameter int          VL_W         = 7,
    parameter logic [31:0] RESET_PC     = 32'h0,
    parameter int          WIDE_BYTES   = 8,
    parameter int          NARROW_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic             commit,
    input  logic             ex_pc_we,
    input  logic [PC_W-1:0]  ex_pc_wd,
    input  logic             ex_msr_we,
    input  logic [MSR_W-1:0] ex_msr_wd,
    input  logic             ex_vst_we,
    input  logic [VL_W-1:0]  ex_vl_wd,
    input  logic [VL_W-1:0]  ex_step_wd,
    input  logic             pc_adv,
    input  logic             pc_adv_wide,
    input  logic             step_clr,
    input  logic             step_adv,
    input  logic [VL_W-1:0]  step_nxt,
    output logic [PC_W-1:0]  pc_q,
    output logic [MSR_W-1:0] msr_q,
    output logic [VL_W-1:0]  vl_q,
    output logic [VL_W-1:0]  step_q,
    output logic [MSR_W-1:0] snap_msr
);
    localparam logic [PC_W-1:0] PC_RST  = PC_W'(RESET_PC);
    localparam logic [PC_W-1:0] INC_WID = PC_W'(WIDE_BYTES);
    localparam logic [PC_W-1:0] INC_NAR = PC_W'(NARROW_BYTES);

    logic [PC_W-1:0] pc_inc;

    // Select the fall-through increment.
    always_comb pc_inc = pc_adv_wide ? INC_WID : INC_NAR;

    // Program counter: execution write, else sequencer advance.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pc_q <= PC_RST;
        else if (commit && ex_pc_we)  pc_q <= ex_pc_wd;
        else if (pc_adv)              pc_q <= pc_q + pc_inc;
    end

    // Machine state: written only by execution.
    always_ff @(posedge clk) begin
        if (!rst_n)                   msr_q <= '0;
        else if (commit && ex_msr_we) msr_q <= ex_msr_wd;
    end

    // Vector state: execution write, else loop clear or step write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q   <= '0;
            step_q <= '0;
        end else if (commit && ex_vst_we) begin
            vl_q   <= ex_vl_wd;
            step_q <= ex_step_wd;
        end else if (step_clr) begin
            step_q <= '0;
        end else if (step_adv) begin
            step_q <= step_nxt;
        end
    end

    // Snapshot of the machine state seen by the accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)   snap_msr <= '0;
        else if (cap) snap_msr <= msr_q;
    end
endmodule

// File: rtl/vloop_ctrl.sv
// Fetch / issue / wait state machine. Decides at acceptance whether to
// issue, skip or flag an illegal prefix, and at completion whether to
// continue the loop, end it, or leave on a state write (exception).
// Assumes ex_done is never high in the cycle ex_start is high.
module vloop_ctrl
    import vloop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_ack,
    input  dec_t f_dec,
    input  logic skip,
    input  logic last,
    input  logic ex_done,
    input  logic ex_pc_we,
    input  logic ex_vst_we,
    output logic fetch_req,
    output logic ex_start,
    output logic cap,
    output logic commit,
    output logic step_adv,
    output logic step_clr,
    output logic pc_adv,
    output logic pc_adv_wide,
    output dec_t l_dec,
    output logic illegal_o,
    output logic exc_o
);
    seq_st_e st, st_nxt;
    logic    ill_set, exc_set;

    // State outputs.
    always_comb begin
        fetch_req = (st == ST_FETCH);
        ex_start  = (st == ST_ISSUE);
    end

    // Next state and the per-cycle register update strobes.
    always_comb begin
        st_nxt      = st;
        cap         = 1'b0;
        commit      = 1'b0;
        step_adv    = 1'b0;
        step_clr    = 1'b0;
        pc_adv      = 1'b0;
        pc_adv_wide = 1'b0;
        ill_set     = 1'b0;
        exc_set     = 1'b0;
        case (st)
            ST_FETCH: begin
                if (fetch_ack) begin
                    if (f_dec.pfx && (f_dec.cls != CLS_NORM)) begin
                        ill_set = 1'b1;
                    end else if (f_dec.pfx && skip) begin
                        step_clr    = 1'b1;
                        pc_adv      = 1'b1;
                        pc_adv_wide = 1'b1;
                    end else begin
                        cap    = 1'b1;
                        st_nxt = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: st_nxt = ST_WAIT;
            ST_WAIT: begin
                if (ex_done) begin
                    commit = 1'b1;
                    st_nxt = ST_FETCH;
                    if (l_dec.cls != CLS_NORM) begin
                        pc_adv = 1'b1;
                    end else if (ex_pc_we || ex_vst_we) begin
                        exc_set = 1'b1;
                    end else if (!l_dec.pfx) begin
                        pc_adv = 1'b1;
                    end else if (l_dec.nvo || last) begin
                        step_clr    = 1'b1;
                        pc_adv      = 1'b1;
                        pc_adv_wide = 1'b1;
                    end else begin
                        step_adv = 1'b1;
                        st_nxt   = ST_ISSUE;
                    end
                end
            end
            default: st_nxt = ST_FETCH;
        endcase
    end

    // State, latched decode and the registered indication pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_FETCH;
            l_dec     <= '0;
            illegal_o <= 1'b0;
            exc_o     <= 1'b0;
        end else begin
            st        <= st_nxt;
            illegal_o <= ill_set;
            exc_o     <= exc_set;
            if (cap) l_dec <= f_dec;
        end
    end
endmodule

// File: rtl/vloop_seq.sv
// Top of the vector loop issue sequencer: wires the state machine, the
// local element counter and the architectural state registers together.
module vloop_seq
    import vloop_pkg::*;
#(
    parameter int          PC_W         = 32,
    parameter int          MSR_W        = 16,
    parameter int          VL_W         = 7,
    parameter logic [31:0] RESET_PC     = 32'h0,
    parameter int          WIDE_BYTES   = 8,
    parameter int          NARROW_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             fetch_req,
    output logic [PC_W-1:0]  fetch_pc,
    input  logic             fetch_ack,
    input  logic             fetch_pfx,
    input  logic [1:0]       fetch_cls,
    input  logic             fetch_nvo,
    output logic             ex_start,
    output logic [VL_W-1:0]  ex_step,
    output logic             ex_vec,
    output logic [1:0]       ex_cls,
    output logic [MSR_W-1:0] ex_msr,
    input  logic             ex_done,
    input  logic             ex_pc_we,
    input  logic [PC_W-1:0]  ex_pc_wd,
    input  logic             ex_msr_we,
    input  logic [MSR_W-1:0] ex_msr_wd,
    input  logic             ex_vst_we,
    input  logic [VL_W-1:0]  ex_vl_wd,
    input  logic [VL_W-1:0]  ex_step_wd,
    output logic [PC_W-1:0]  pc_o,
    output logic [MSR_W-1:0] msr_o,
    output logic [VL_W-1:0]  vl_o,
    output logic [VL_W-1:0]  step_o,
    output logic             illegal_o,
    output logic             exc_o
);
    dec_t            f_dec, l_dec;
    logic            cap, commit, step_adv, step_clr, pc_adv, pc_adv_wide;
    logic            skip, last;
    logic [VL_W-1:0] step_nxt;

    // Pack the decoded fetch flags.
    always_comb begin
        f_dec.pfx = fetch_pfx;
        f_dec.cls = icls_e'(fetch_cls);
        f_dec.nvo = fetch_nvo;
    end

    vloop_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_ack   (fetch_ack),
        .f_dec       (f_dec),
        .skip        (skip),
        .last        (last),
        .ex_done     (ex_done),
        .ex_pc_we    (ex_pc_we),
        .ex_vst_we   (ex_vst_we),
        .fetch_req   (fetch_req),
        .ex_start    (ex_start),
        .cap         (cap),
        .commit      (commit),
        .step_adv    (step_adv),
        .step_clr    (step_clr),
        .pc_adv      (pc_adv),
        .pc_adv_wide (pc_adv_wide),
        .l_dec       (l_dec),
        .illegal_o   (illegal_o),
        .exc_o       (exc_o)
    );

    vloop_step #(.VL_W(VL_W)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .adv      (step_adv),
        .step_in  (step_o),
        .vl_in    (vl_o),
        .cur_step (ex_step),
        .step_nxt (step_nxt),
        .skip     (skip),
        .last     (last)
    );

    vloop_regs #(
        .PC_W         (PC_W),
        .MSR_W        (MSR_W),
        .VL_W         (VL_W),
        .RESET_PC     (RESET_PC),
        .WIDE_BYTES   (WIDE_BYTES),
        .NARROW_BYTES (NARROW_BYTES)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap         (cap),
        .commit      (commit),
        .ex_pc_we    (ex_pc_we),
        .ex_pc_wd    (ex_pc_wd),
        .ex_msr_we   (ex_msr_we),
        .ex_msr_wd   (ex_msr_wd),
        .ex_vst_we   (ex_vst_we),
        .ex_vl_wd    (ex_vl_wd),
        .ex_step_wd  (ex_step_wd),
        .pc_adv      (pc_adv),
        .pc_adv_wide (pc_adv_wide),
        .step_clr    (step_clr),
        .step_adv    (step_adv),
        .step_nxt    (step_nxt),
        .pc_q        (pc_o),
        .msr_q       (msr_o),
        .vl_q        (vl_o),
        .step_q      (step_o),
        .snap_msr    (ex_msr)
    );

    // Latched decode presented to the execution unit.
    always_comb begin
        fetch_pc = pc_o;
        ex_vec   = l_dec.pfx;
        ex_cls   = l_dec.cls;
    end
endmodule

// File: rtl/vloop_seq_chk.sv
// Protocol checker for vloop_seq, attached by bind. Observes ports only.
module vloop_seq_chk #(
    parameter int PC_W = 32,
    parameter int VL_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_req,
    input logic            ex_start,
    input logic [VL_W-1:0] ex_step,
    input logic [VL_W-1:0] step_o,
    input logic [PC_W-1:0] pc_o,
    input logic            illegal_o,
    input logic            exc_o
);
    p_no_start_in_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> !ex_start);

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ex_start |=> !ex_start);

    p_step_writeback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ex_start |-> (step_o == ex_step));

    p_step_increment_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_start && !$past(fetch_req)) |-> (ex_step == VL_W'($past(ex_step) + 1'b1)));

    p_pc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |-> $stable(pc_o));

    p_exc_to_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> fetch_req);

    p_exc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |=> !exc_o);

    p_illegal_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (fetch_req && !ex_start));
endmodule

bind vloop_seq vloop_seq_chk #(.PC_W(PC_W), .VL_W(VL_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_req (fetch_req),
    .ex_start  (ex_start),
    .ex_step   (ex_step),
    .step_o    (step_o),
    .pc_o      (pc_o),
    .illegal_o (illegal_o),
    .exc_o     (exc_o)
);

// File: tb/test_vloop_seq.sv
// Bench for vloop_seq: directed corners plus seeded random instruction mix,
// checked against a behavioural model of the architectural state.
module test_vloop_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 32;
    localparam int MSR_W      = 16;
    localparam int VL_W       = 7;
    localparam int LIMIT      = 150000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fetch_req, fetch_ack = 0, fetch_pfx = 0, fetch_nvo = 0;
    logic [1:0] fetch_cls = 0, ex_cls;
    logic [PC_W-1:0] fetch_pc, ex_pc_wd = 0, pc_o;
    logic ex_start, ex_vec, ex_done = 0, ex_pc_we = 0, ex_msr_we = 0, ex_vst_we = 0;
    logic [VL_W-1:0] ex_step, ex_vl_wd = 0, ex_step_wd = 0, vl_o, step_o;
    logic [MSR_W-1:0] ex_msr, ex_msr_wd = 0, msr_o;
    logic illegal_o, exc_o;

    vloop_seq i_vloop_seq (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_run = 0, n_fail = 0;
    int c_ill = 0, c_exc = 0, c_start = 0;
    int e_ill = 0, e_exc = 0, e_start = 0;
    logic [PC_W-1:0]  m_pc;
    logic [MSR_W-1:0] m_msr;
    logic [VL_W-1:0]  m_vl, m_step;

    // Pulse counters, sampled at the clock edge.
    always @(posedge clk) begin
        if (rst_n) begin
            if (illegal_o) c_ill++;
            if (exc_o)     c_exc++;
            if (ex_start)  c_start++;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [PC_W-1:0] pc_next(input logic [PC_W-1:0] pc, input bit wide);
        return pc + (wide ? 32'd8 : 32'd4);
    endfunction

    function automatic bit loop_ends(input int k, input logic [VL_W-1:0] vl, input bit nvo);
        return nvo || ((k + 1) >= int'(vl));
    endfunction

    // One instruction: accept, serve every element, then compare the state.
    task automatic run_op(input bit pfx, input logic [1:0] cls, input bit nvo,
                          input int exc_elem, input bit exc_vst, input bit take,
                          input logic [PC_W-1:0] npc, input logic [MSR_W-1:0] nmsr,
                          input logic [VL_W-1:0] nvl, input logic [VL_W-1:0] nstep);
        int k, e;
        bit fin, pwe, mwe, vwe;
        logic [MSR_W-1:0] msr_at_fetch;
        while (!fetch_req) @(negedge clk);
        msr_at_fetch = m_msr;
        fetch_ack = 1; fetch_pfx = pfx; fetch_cls = cls; fetch_nvo = nvo;
        @(negedge clk);
        fetch_ack = 0;
        if (pfx && cls != 2'd0) begin
            e_ill++;
        end else if (pfx && m_step >= m_vl) begin
            m_step = '0; m_pc = pc_next(m_pc, 1);
        end else begin
            k = int'(m_step); e = 0; fin = 0;
            while (!fin) begin
                chk(pfx ? "R3 start timing" : "R3 scalar start timing", {63'd0, ex_start}, 64'd1);
                while (!ex_start) @(negedge clk);
                e_start++;
                chk("R4 element index", {57'd0, ex_step}, k);
                chk("R2 msr snapshot", {48'd0, ex_msr}, {48'd0, msr_at_fetch});
                chk("R2 prefix and class", {61'd0, ex_vec, ex_cls}, {61'd0, pfx, cls});
                @(negedge clk);
                repeat ($urandom % 3) @(negedge clk);
                pwe = 0; mwe = 0; vwe = 0;
                if (cls == 2'd1) vwe = 1;
                else if (cls == 2'd2) pwe = take;
                else if (cls == 2'd3) begin pwe = 1; mwe = 1; end
                else if (e == exc_elem) begin pwe = 1; vwe = exc_vst; end
                ex_done = 1; ex_pc_we = pwe; ex_pc_wd = npc; ex_msr_we = mwe; ex_msr_wd = nmsr;
                ex_vst_we = vwe; ex_vl_wd = nvl; ex_step_wd = nstep;
                @(negedge clk);
                ex_done = 0; ex_pc_we = 0; ex_msr_we = 0; ex_vst_we = 0;
                fin = 1;
                if (cls != 2'd0) begin
                    m_pc = pwe ? npc : pc_next(m_pc, 0);
                    if (mwe) m_msr = nmsr;
                    if (vwe) begin m_vl = nvl; m_step = nstep; end
                end else if (pwe) begin
                    e_exc++; m_pc = npc;
                    if (vwe) begin m_vl = nvl; m_step = nstep; end
                    else m_step = VL_W'(k);
                end else if (!pfx) begin
                    m_pc = pc_next(m_pc, 0);
                end else if (loop_ends(k, m_vl, nvo)) begin
                    m_step = '0; m_pc = pc_next(m_pc, 1);
                end else begin
                    k++; e++; m_step = VL_W'(k); fin = 0;
                end
            end
        end
        while (!fetch_req) @(negedge clk);
        @(negedge clk);
        chk("R5 R8 R10 R11 pc", {32'd0, pc_o}, {32'd0, m_pc});
        chk("R4 R5 R7 step", {57'd0, step_o}, {57'd0, m_step});
        chk("R8 vl", {57'd0, vl_o}, {57'd0, m_vl});
        chk("R8 msr", {48'd0, msr_o}, {48'd0, m_msr});
        chk("R9 illegal pulses", c_ill, e_ill);
        chk("R7 exception pulses", c_exc, e_exc);
        chk("R3 R9 R11 start count", c_start, e_start);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (LIMIT) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd5521));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 fetch_req", {63'd0, fetch_req}, 64'd1);
        chk("R1 ex_start", {63'd0, ex_start}, 64'd0);
        chk("R1 pc", {32'd0, pc_o}, 64'd0);
        chk("R1 state", {50'd0, msr_o, vl_o, step_o}, 64'd0);
        m_pc = 0; m_msr = 0; m_vl = 0; m_step = 0;
        // R11 vl zero skips
        run_op(1, 0, 0, -1, 0, 0, 0, 0, 0, 0);
        // R8 length set to 3
        run_op(0, 1, 0, -1, 0, 0, 0, 0, 7'd3, 7'd0);
        // R5 full loop of three
        run_op(1, 0, 0, -1, 0, 0, 0, 0, 0, 0);
        // R6 no vector output ends after one element
        run_op(1, 0, 1, -1, 0, 0, 0, 0, 0, 0);
        // R9 prefixed branch
        run_op(1, 2, 0, -1, 0, 1, 32'h100, 0, 0, 0);
        // R10 scalar normal
        run_op(0, 0, 0, -1, 0, 0, 0, 0, 0, 0);
        // R7 exception at element 1, then with a vector state write
        run_op(1, 0, 0, 1, 0, 0, 32'h200, 0, 0, 0);
        run_op(0, 1, 0, -1, 0, 0, 0, 0, 7'd6, 7'd2);
        run_op(1, 0, 0, 2, 1, 0, 32'h300, 0, 7'd5, 7'd1);
        // R11 step beyond length
        run_op(0, 1, 0, -1, 0, 0, 0, 0, 7'd2, 7'd4);
        run_op(1, 0, 0, -1, 0, 0, 0, 0, 0, 0);
        // R2 trap rewrites msr; the next loop must see it
        run_op(0, 3, 0, -1, 0, 0, 32'h400, 16'hbeef, 0, 0);
        run_op(0, 1, 0, -1, 0, 0, 0, 0, 7'd4, 7'd0);
        run_op(1, 0, 0, -1, 0, 0, 0, 0, 0, 0);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            bit p, n, t, xv;
            logic [1:0] c;
            int x;
            p  = ($urandom % 3) != 0;
            c  = (($urandom % 4) == 0) ? 2'($urandom % 4) : 2'd0;
            n  = ($urandom % 8) == 0;
            x  = (($urandom % 8) == 0) ? int'($urandom % 6) : -1;
            xv = $urandom % 2;
            t  = $urandom % 2;
            run_op(p, c, n, x, xv, t, $urandom & 32'hffff_fffc, 16'($urandom),
                   7'($urandom % 10), 7'($urandom % 4));
        end
        summary();
        $finish;
    end
endmodule